// File: doc/BRIEF.md
# Paired-Register Operand File

This block is the general register file of a 32-bit core: 32 registers of 32 bits each. It can also serve 64-bit operands, both double-precision floats and 64-bit integers, by joining two registers into a pair. Single-width instructions use an ordinary 32-bit read port and write port, addressed directly.

Wide instructions name their operands through the instruction word. Each operand has a 5-bit register field and a 1-bit stride flag, and together they form a 6-bit pair selector. The field gives the first register of the pair. The partner register sits one or two places above it, depending on the flag. The stride of two lets a pair skip a register, for example when the pair starts in the upper, callee-saved half of the file. The block decodes the three selectors (destination D, source A, source B) from the instruction word. It provides two combinational 64-bit read ports for A and B and one 64-bit write port for D. It also raises a flag when a conversion instruction carries a nonzero value in its reserved bit.

Top module: `pairreg_file`

## Requirements
- R1: While `rst_n` is low, every register is cleared to zero. Afterwards each of them reads zero until it is written.
- R2: The instruction word is decoded as follows. D register field is bits [25:21] with stride flag bit 10. A register field is bits [20:16] with stride flag bit 9. B register field is bits [15:11] with stride flag bit 8.
- R3: The partner register is the first register plus 1 when the stride flag is 0, and plus 2 when it is 1. The index wraps modulo 32. Every first index 0 to 31 is valid with either stride.
- R4: A 64-bit read returns the first register in bits [63:32] and the partner register in bits [31:0]. Port A and port B are independent.
- R5: When `wr64_en` is high, a clock edge stores `wr64_data[63:32]` into the first D register and `wr64_data[31:0]` into the D partner, both on the same edge.
- R6: Register 0 always reads zero. It ignores 32-bit writes and writes to either half of a pair.
- R7: `pair_ovf` bit 2 (D), bit 1 (A) and bit 0 (B) is high exactly when that operand's partner index wrapped past 31.
- R8: `rd32_data` shows register `rd32_addr`. When `wr32_en` is high, a clock edge writes `wr32_data` into register `wr32_addr`.
- R9: If a 32-bit write and a 64-bit write reach the same register on the same edge, the 64-bit data is stored. A 32-bit write to any other register still takes effect.
- R10: All reads are combinational. During a write cycle they show the old contents until the clock edge.
- R11: `illegal_enc` is high exactly when `cvt_op` is high and instruction bit 8 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn | input | 32 | Instruction word carrying the three pair selectors |
| cvt_op | input | 1 | Current instruction is a 64-bit int/float conversion |
| rd64_a | output | 64 | Pair read for source A |
| rd64_b | output | 64 | Pair read for source B |
| wr64_en | input | 1 | Write the D pair on this edge |
| wr64_data | input | 64 | Data for the D pair |
| rd32_addr | input | 5 | Single-width read index |
| rd32_data | output | 32 | Single-width read data |
| wr32_en | input | 1 | Single-width write enable |
| wr32_addr | input | 5 | Single-width write index |
| wr32_data | input | 32 | Single-width write data |
| pair_ovf | output | 3 | Partner wrap per operand: bit 2 D, bit 1 A, bit 0 B |
| illegal_enc | output | 1 | Reserved bit set on a conversion instruction |

## Verification
Each of the 64 pair selectors is used in turn as the destination. Each write carries a distinct upper and lower word, so swapped halves, a wrong stride and a wrong wrap all show up as mismatches. Every written pair is read back through A while B reads a different selector. This separates the two flag bits and the three register fields from one another. The wrapping selectors (first index 30 or 31) place a half on register 0 and cover the discard of writes to register 0. A sweep over single-width writes, same-edge collisions between the two write ports, and all four combinations of `cvt_op` and bit 8 cover the remaining rules.

// File: rtl/pairreg_pkg.sv
package pairreg_pkg;

  // Index width is fixed by the 5-bit register fields of the instruction.
  localparam int IDX_W = 5;
  localparam int NREG  = 1 << IDX_W;
  localparam int SEL_W = IDX_W + 1;

  // Operand order used throughout: 0 = D, 1 = A, 2 = B.
  localparam int NOPS = 3;

  typedef struct packed {
    logic [IDX_W-1:0] first;
    logic [IDX_W-1:0] partner;
    logic             wrap;
  } pair_t;

  // Join a stride flag and a register field into a pair selector.
  function automatic logic [SEL_W-1:0] sel_join(input logic flag,
                                                input logic [IDX_W-1:0] field);
    return {flag, field};
  endfunction

  // Resolve a selector into its two register indices.
  function automatic pair_t sel_resolve(input logic [SEL_W-1:0] sel);
    pair_t           p;
    logic [IDX_W:0]  sum;
    sum       = {1'b0, sel[IDX_W-1:0]} + (sel[IDX_W] ? (IDX_W+1)'(2) : (IDX_W+1)'(1));
    p.first   = sel[IDX_W-1:0];
    p.partner = sum[IDX_W-1:0];
    p.wrap    = sum[IDX_W];
    return p;
  endfunction

endpackage

// File: rtl/pairsel_decode.sv
module pairsel_decode
  import pairreg_pkg::*;
(
  input  logic [25:8] fields,
  input  logic        cvt_op,
  output pair_t       pairs [NOPS],
  output logic        illegal_enc
);

  // Field positions are given relative to bit 0 of the full instruction word.
  localparam int FLD_LSB  [NOPS] = '{21, 16, 11};
  localparam int FLAG_BIT [NOPS] = '{10, 9, 8};
  localparam int RSV_BIT         = 8;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    logic [SEL_W-1:0] sel;
    assign sel      = sel_join(fields[FLAG_BIT[g]], fields[FLD_LSB[g] +: IDX_W]);
    assign pairs[g] = sel_resolve(sel);
  end

  assign illegal_enc = cvt_op & fields[RSV_BIT];

endmodule

// File: rtl/pair_write_steer.sv
module pair_write_steer
  import pairreg_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             w64_en,
  input  pair_t            dst,
  input  logic [2*XLEN-1:0] w64_data,
  input  logic             w32_en,
  input  logic [IDX_W-1:0] w32_addr,
  input  logic [XLEN-1:0]  w32_data,
  output logic [NREG-1:0]  we,
  output logic [NREG-1:0][XLEN-1:0] wd,
  output logic             w32_shadowed
);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic hit_hi, hit_lo, hit_32;
    assign hit_hi = w64_en && (dst.first   == IDX_W'(i));
    assign hit_lo = w64_en && (dst.partner == IDX_W'(i));
    assign hit_32 = w32_en && (w32_addr    == IDX_W'(i));

    if (i == 0) begin : g_zero
      assign we[i] = 1'b0;
      assign wd[i] = '0;
    end else begin : g_live
      assign we[i] = hit_hi | hit_lo | hit_32;
      always_comb begin
        if (hit_hi)      wd[i] = w64_data[2*XLEN-1:XLEN];
        else if (hit_lo) wd[i] = w64_data[XLEN-1:0];
        else             wd[i] = w32_data;
      end
    end
  end

  assign w32_shadowed = w32_en && w64_en &&
                        ((w32_addr == dst.first) || (w32_addr == dst.partner));

endmodule

// File: rtl/regfile_core.sv
module regfile_core
  import pairreg_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NRD  = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NREG-1:0]           we,
  input  logic [NREG-1:0][XLEN-1:0] wd,
  input  logic [IDX_W-1:0]          rd_idx  [NRD],
  output logic [XLEN-1:0]           rd_data [NRD],
  output logic [NREG-1:0][XLEN-1:0] mem_view
);

  assign mem_view[0] = '0;

  for (genvar i = 1; i < NREG; i++) begin : g_store
    logic [XLEN-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (we[i]) q <= wd[i];
    end
    assign mem_view[i] = q;
  end

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    assign rd_data[k] = mem_view[rd_idx[k]];
  end

endmodule

// File: rtl/pairreg_file.sv
module pairreg_file
  import pairreg_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [31:0]        insn,
  input  logic               cvt_op,
  output logic [2*XLEN-1:0]  rd64_a,
  output logic [2*XLEN-1:0]  rd64_b,
  input  logic               wr64_en,
  input  logic [2*XLEN-1:0]  wr64_data,
  input  logic [4:0]         rd32_addr,
  output logic [XLEN-1:0]    rd32_data,
  input  logic               wr32_en,
  input  logic [4:0]         wr32_addr,
  input  logic [XLEN-1:0]    wr32_data,
  output logic [2:0]         pair_ovf,
  output logic               illegal_enc
);

  localparam int NRD   = 5;
  localparam int OP_D  = 0;
  localparam int OP_A  = 1;
  localparam int OP_B  = 2;

  pair_t                     pairs [NOPS];
  logic [NREG-1:0]           we;
  logic [NREG-1:0][XLEN-1:0] wd;
  logic [NREG-1:0][XLEN-1:0] mem_view;
  logic [IDX_W-1:0]          rd_idx  [NRD];
  logic [XLEN-1:0]           rd_data [NRD];
  logic                      w32_shadowed;
  logic                      unused_insn_bits;

  // Named views of the decoded indices for the checker.
  logic [IDX_W-1:0] d_first, d_partner, a_first, a_partner;

  assign unused_insn_bits = ^{insn[31:26], insn[7:0], w32_shadowed};

  pairsel_decode u_decode (
    .fields      (insn[25:8]),
    .cvt_op      (cvt_op),
    .pairs       (pairs),
    .illegal_enc (illegal_enc)
  );

  pair_write_steer #(.XLEN(XLEN)) u_steer (
    .w64_en       (wr64_en),
    .dst          (pairs[OP_D]),
    .w64_data     (wr64_data),
    .w32_en       (wr32_en),
    .w32_addr     (wr32_addr),
    .w32_data     (wr32_data),
    .we           (we),
    .wd           (wd),
    .w32_shadowed (w32_shadowed)
  );

  assign rd_idx[0] = pairs[OP_A].first;
  assign rd_idx[1] = pairs[OP_A].partner;
  assign rd_idx[2] = pairs[OP_B].first;
  assign rd_idx[3] = pairs[OP_B].partner;
  assign rd_idx[4] = rd32_addr;

  regfile_core #(.XLEN(XLEN), .NRD(NRD)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (we),
    .wd       (wd),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .mem_view (mem_view)
  );

  assign rd64_a    = {rd_data[0], rd_data[1]};
  assign rd64_b    = {rd_data[2], rd_data[3]};
  assign rd32_data = rd_data[4];

  assign pair_ovf  = {pairs[OP_D].wrap, pairs[OP_A].wrap, pairs[OP_B].wrap};

  assign d_first   = pairs[OP_D].first;
  assign d_partner = pairs[OP_D].partner;
  assign a_first   = pairs[OP_A].first;
  assign a_partner = pairs[OP_A].partner;

endmodule

// File: rtl/pairreg_checker.sv
module pairreg_checker
  import pairreg_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cvt_op,
  input logic                      illegal_enc,
  input logic [2:0]                pair_ovf,
  input logic [IDX_W-1:0]          d_first,
  input logic [IDX_W-1:0]          d_partner,
  input logic [IDX_W-1:0]          a_first,
  input logic [IDX_W-1:0]          a_partner,
  input logic                      wr64_en,
  input logic [2*XLEN-1:0]         wr64_data,
  input logic                      wr32_en,
  input logic [IDX_W-1:0]          wr32_addr,
  input logic [XLEN-1:0]           wr32_data,
  input logic [IDX_W-1:0]          rd32_addr,
  input logic [XLEN-1:0]           rd32_data,
  input logic [2*XLEN-1:0]         rd64_a,
  input logic [NREG-1:0][XLEN-1:0] mem_view
);

  // R3: partner is one or two above the first register, modulo the file size
  a_r3_stride: assert property (@(posedge clk) disable iff (!rst_n)
    ((d_partner - d_first) == IDX_W'(1)) || ((d_partner - d_first) == IDX_W'(2)));

  // R7: a wrap flag means the partner index fell below the first index
  a_r7_wrap_low: assert property (@(posedge clk) disable iff (!rst_n)
    pair_ovf[2] |-> (d_partner < d_first));

  a_r7_no_wrap_high: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_ovf[2] |-> (d_partner > d_first));

  // R4: read port A places the first register on top
  a_r4_read_order: assert property (@(posedge clk) disable iff (!rst_n)
    (rd64_a[2*XLEN-1:XLEN] == mem_view[a_first]) && (rd64_a[XLEN-1:0] == mem_view[a_partner]));

  // R5: both halves land on the same edge
  a_r5_write_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (wr64_en && d_first != '0) |=> (mem_view[$past(d_first)] == $past(wr64_data[2*XLEN-1:XLEN])));

  a_r5_write_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (wr64_en && d_partner != '0) |=> (mem_view[$past(d_partner)] == $past(wr64_data[XLEN-1:0])));

  // R6: register 0 reads zero through the single-width port
  a_r6_zero_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (rd32_addr == '0) |-> (rd32_data == '0));

  // R8: an unopposed 32-bit write is stored
  a_r8_write32: assert property (@(posedge clk) disable iff (!rst_n)
    (wr32_en && wr32_addr != '0 && !(wr64_en && (wr32_addr == d_first || wr32_addr == d_partner)))
      |=> (mem_view[$past(wr32_addr)] == $past(wr32_data)));

  // R10: without any write the contents stay put
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr64_en && !wr32_en) |=> $stable(mem_view));

  // R11: the illegal flag only appears on conversion instructions
  a_r11_illegal_gate: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_enc |-> cvt_op);

endmodule

bind pairreg_file pairreg_checker #(.XLEN(XLEN)) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .cvt_op      (cvt_op),
  .illegal_enc (illegal_enc),
  .pair_ovf    (pair_ovf),
  .d_first     (d_first),
  .d_partner   (d_partner),
  .a_first     (a_first),
  .a_partner   (a_partner),
  .wr64_en     (wr64_en),
  .wr64_data   (wr64_data),
  .wr32_en     (wr32_en),
  .wr32_addr   (wr32_addr),
  .wr32_data   (wr32_data),
  .rd32_addr   (rd32_addr),
  .rd32_data   (rd32_data),
  .rd64_a      (rd64_a),
  .mem_view    (mem_view)
);

// File: tb/test_pairreg_file.sv
module test_pairreg_file;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] insn = '0;
  logic        cvt_op = 1'b0;
  logic [63:0] rd64_a, rd64_b;
  logic        wr64_en = 1'b0;
  logic [63:0] wr64_data = '0;
  logic [4:0]  rd32_addr = '0;
  logic [31:0] rd32_data;
  logic        wr32_en = 1'b0;
  logic [4:0]  wr32_addr = '0;
  logic [31:0] wr32_data = '0;
  logic [2:0]  pair_ovf;
  logic        illegal_enc;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [31:0] model [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  pairreg_file i_pairreg_file (
    .clk(clk), .rst_n(rst_n), .insn(insn), .cvt_op(cvt_op),
    .rd64_a(rd64_a), .rd64_b(rd64_b), .wr64_en(wr64_en), .wr64_data(wr64_data),
    .rd32_addr(rd32_addr), .rd32_data(rd32_data), .wr32_en(wr32_en),
    .wr32_addr(wr32_addr), .wr32_data(wr32_data), .pair_ovf(pair_ovf),
    .illegal_enc(illegal_enc)
  );

  // Bench-side arithmetic for the pair rules.
  function automatic int first_of(input int sel);
    return sel % 32;
  endfunction
  function automatic int partner_of(input int sel);
    return (sel % 32 + ((sel >= 32) ? 2 : 1)) % 32;
  endfunction
  function automatic bit wraps(input int sel);
    return (sel % 32 + ((sel >= 32) ? 2 : 1)) >= 32;
  endfunction
  // R2 layout: fields at [25:21],[20:16],[15:11], flags at bits 10,9,8.
  function automatic logic [31:0] mk_insn(input int d, input int a, input int b);
    logic [31:0] w;
    w = '0;
    w[25:21] = 5'(d % 32);
    w[20:16] = 5'(a % 32);
    w[15:11] = 5'(b % 32);
    w[10]    = (d >= 32);
    w[9]     = (a >= 32);
    w[8]     = (b >= 32);
    return w;
  endfunction
  function automatic logic [63:0] pair_val(input int sel);
    return {model[first_of(sel)], model[partner_of(sel)]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_edge_then_settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stimulus
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: every register reads zero after reset
    for (int i = 0; i < 32; i++) begin
      rd32_addr = 5'(i);
      #1 chk("R1 reset value", {32'h0, rd32_data}, 64'h0);
    end

    // Sweep every destination selector (R2, R3, R4, R5, R6, R7, R10)
    for (int sel = 0; sel < 64; sel++) begin
      logic [31:0] hi, lo;
      int bsel;
      hi = 32'hA500_0000 ^ (32'(sel) * 32'h0001_0203);
      lo = 32'h5A00_0001 ^ (32'(sel) * 32'h0304_0105);
      insn      = mk_insn(sel, sel, sel);
      wr64_en   = 1'b1;
      wr64_data = {hi, lo};
      #1;
      chk("R10 old value before edge", rd64_a, pair_val(sel));
      chk("R7 D wrap flag", {63'h0, pair_ovf[2]}, {63'h0, wraps(sel)});
      wait_edge_then_settle();
      wr64_en = 1'b0;
      if (first_of(sel) != 0)   model[first_of(sel)]   = hi;
      if (partner_of(sel) != 0) model[partner_of(sel)] = lo;
      bsel = (sel + 17) % 64;
      insn = mk_insn((sel + 40) % 64, sel, bsel);
      #1;
      chk("R5 R4 R3 pair read A", rd64_a, pair_val(sel));
      chk("R2 R4 pair read B", rd64_b, pair_val(bsel));
      chk("R7 A and B wrap flags", {61'h0, pair_ovf},
          {61'h0, wraps((sel + 40) % 64), wraps(sel), wraps(bsel)});
      rd32_addr = 5'd0;
      #1 chk("R6 register 0 after pair write", {32'h0, rd32_data}, 64'h0);
    end

    // R8: single-width write then read of every register
    for (int i = 0; i < 32; i++) begin
      wr32_en   = 1'b1;
      wr32_addr = 5'(i);
      wr32_data = 32'hC0DE_0000 + 32'(i * 7);
      wait_edge_then_settle();
      wr32_en = 1'b0;
      if (i != 0) model[i] = 32'hC0DE_0000 + 32'(i * 7);
    end
    for (int i = 0; i < 32; i++) begin
      rd32_addr = 5'(i);
      #1 chk(i == 0 ? "R6 register 0 ignores 32-bit write" : "R8 single-width read",
             {32'h0, rd32_data}, {32'h0, model[i]});
    end

    // R9: collisions between the two write ports
    insn      = mk_insn(5, 5, 9);
    wr64_en   = 1'b1;
    wr64_data = 64'h1111_2222_3333_4444;
    wr32_en   = 1'b1;
    wr32_addr = 5'd5;
    wr32_data = 32'hDEAD_BEEF;
    wait_edge_then_settle();
    #1 chk("R9 collision on first register", rd64_a, 64'h1111_2222_3333_4444);

    wr64_data = 64'h5555_6666_7777_8888;
    wr32_addr = 5'd6;
    wait_edge_then_settle();
    #1 chk("R9 collision on partner register", rd64_a, 64'h5555_6666_7777_8888);

    wr64_data = 64'h0102_0304_0506_0708;
    wr32_addr = 5'd9;
    wr32_data = 32'hFACE_0009;
    wait_edge_then_settle();
    wr64_en = 1'b0;
    wr32_en = 1'b0;
    #1;
    chk("R9 both writes on distinct registers", rd64_a, 64'h0102_0304_0506_0708);
    rd32_addr = 5'd9;
    #1 chk("R9 32-bit write beside pair write", {32'h0, rd32_data}, 64'h0000_0000_FACE_0009);

    // R11: reserved bit on conversion instructions
    for (int c = 0; c < 2; c++) begin
      for (int b8 = 0; b8 < 2; b8++) begin
        insn   = mk_insn(3, 7, b8 * 32 + 12);
        cvt_op = c[0];
        #1 chk("R11 illegal encoding flag", {63'h0, illegal_enc}, {63'h0, (c == 1 && b8 == 1)});
      end
    end
    cvt_op = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule